// File: doc/BRIEF.md
# Seeded Eight-Bit Pseudo-Random Sequence Generator

This block is an eight-stage linear feedback shift register that steps once on every rising clock edge. The stages are numbered 7 on the left down to 0 on the right, and data moves one place to the right on each step. The new value for stage 7 is the XOR of stage 0 with the tapped stages 6, 5 and 2. This matches the characteristic polynomial x^8+x^6+x^5+x^2+1. The full register is available in parallel, and stage 0 is also brought out as a serial bit stream.

There are two synchronous control inputs. The first clears every stage. The second loads a one-hot seed, which is the only way to start a useful sequence. All zeros is a fixed point of the feedback, so a cleared register stays cleared until the seed is loaded. From the seed, the register passes through all 255 non-zero states and then repeats.

The block has no data input. Its outputs are produced on every cycle and have no valid/ready handshake: there is no back-pressure. A consumer that cannot accept a value on a given cycle must hold the generator in seed load or take values as they arrive.

Top module: `lfsr8_seeded`

## Requirements
- R1: On a clock edge with neither control asserted, each stage i-1 takes the value that stage i held before the edge, for i from 7 down to 1.
- R2: On that same kind of edge, stage 7 takes the XOR of the prior values of stages 0, 2, 5 and 6. The tap mask 8'b0110_0101 marks these stages, with bit n standing for stage n.
- R3: On a clock edge with `clear_i` high, the state becomes 8'h00.
- R4: On a clock edge with `seed_i` high and `clear_i` low, the state becomes 8'b1000_0000, which is stage 7 set and all other stages clear.
- R5: When `clear_i` and `seed_i` are high on the same edge, the clear takes effect and the seed is ignored.
- R6: `serial_o` always equals stage 0 of `state_o`.
- R7: Once the state is 8'h00, free-running steps leave it at 8'h00.
- R8: Starting from the seed, the state first returns to 8'b1000_0000 after exactly 255 free-running steps. It never shows 8'h00 on the way and visits 255 distinct states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the register steps on every edge |
| clear_i | input | 1 | Synchronous clear to all zeros; has priority over the seed load |
| seed_i | input | 1 | Synchronous load of the one-hot seed 8'b1000_0000 |
| state_o | output | 8 | Current register contents, stage 7 in the MSB |
| serial_o | output | 1 | Serial output, equal to stage 0 |

## Verification
Every result is due one clock edge after the inputs that cause it: a clear, a seed load or a free step all appear on `state_o` just after the next rising edge, and `serial_o` follows in the same cycle with no extra delay. The bench drives the controls on the falling edge. It advances a behavioural model at the rising edge and compares both outputs 2 ns after that edge, well before the next falling edge. Period and lock-up results are counted in steps of this model, so the 255-step return is checked on the exact step it is due.

// File: rtl/lfsr8_pkg.sv
package lfsr8_pkg;
  localparam int LFSR_W = 8;
  typedef logic [LFSR_W-1:0] lfsr_word_t;
  // bit n set: stage n contributes to the feedback (x^8+x^6+x^5+x^2+1)
  localparam lfsr_word_t DEF_TAPS = 8'b0110_0101;
  localparam lfsr_word_t DEF_SEED = 8'b1000_0000;
endpackage

// File: rtl/lfsr8_feedback.sv
module lfsr8_feedback #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'b0110_0101
) (
  input  logic [W-1:0] stages_i,
  output logic         fb_o
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar n = 0; n < W; n++) begin : g_tap
    if (TAPS[n]) begin : g_on
      assign chain[n+1] = chain[n] ^ stages_i[n];
    end else begin : g_off
      assign chain[n+1] = chain[n];
    end
  end
  assign fb_o = chain[W];
endmodule

// File: rtl/lfsr8_cell.sv
module lfsr8_cell #(
  parameter logic LOAD_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (clr)       q <= 1'b0;
    else if (load) q <= LOAD_VAL;
    else           q <= d;
  end
endmodule

// File: rtl/lfsr8_seeded.sv
module lfsr8_seeded
  import lfsr8_pkg::*;
#(
  parameter int W = LFSR_W,
  parameter logic [W-1:0] TAPS = DEF_TAPS,
  parameter logic [W-1:0] SEED = DEF_SEED
) (
  input  logic         clk,
  input  logic         clear_i,
  input  logic         seed_i,
  output logic [W-1:0] state_o,
  output logic         serial_o
);
  localparam int TOP = W - 1;

  logic [W-1:0] q;
  logic [W-1:0] d;
  logic         fb;

  lfsr8_feedback #(.W(W), .TAPS(TAPS)) u_fb (
    .stages_i (q),
    .fb_o     (fb)
  );

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == TOP) begin : g_head
      assign d[i] = fb;
    end else begin : g_body
      assign d[i] = q[i+1];
    end
    lfsr8_cell #(.LOAD_VAL(SEED[i])) u_cell (
      .clk  (clk),
      .clr  (clear_i),
      .load (seed_i),
      .d    (d[i]),
      .q    (q[i])
    );
  end

  assign state_o  = q;
  assign serial_o = q[0];
endmodule

// File: rtl/lfsr8_seeded_chk.sv
module lfsr8_seeded_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'b0110_0101,
  parameter logic [W-1:0] SEED = 8'b1000_0000
) (
  input logic         clk,
  input logic         clear_i,
  input logic         seed_i,
  input logic [W-1:0] state_o,
  input logic         serial_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clear_i || seed_i) armed <= 1'b1;

  wire free_step = !clear_i && !seed_i;

  p_shift_r1: assert property (@(posedge clk) disable iff (!armed)
    free_step |=> state_o[W-2:0] == $past(state_o[W-1:1]));
  p_feedback_r2: assert property (@(posedge clk) disable iff (!armed)
    free_step |=> state_o[W-1] == ^($past(state_o) & TAPS));
  p_clear_r3: assert property (@(posedge clk) disable iff (!armed)
    clear_i |=> state_o == '0);
  p_seed_r4: assert property (@(posedge clk) disable iff (!armed)
    (seed_i && !clear_i) |=> state_o == SEED);
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!armed)
    (seed_i && clear_i) |=> state_o != SEED);
  p_serial_r6: assert property (@(posedge clk) disable iff (!armed)
    free_step |=> serial_o == $past(state_o[1]));
  p_lockup_r7: assert property (@(posedge clk) disable iff (!armed)
    (free_step && state_o == '0) |=> state_o == '0);
  p_no_zero_r8: assert property (@(posedge clk) disable iff (!armed)
    (free_step && state_o != '0) |=> state_o != '0);
endmodule

bind lfsr8_seeded lfsr8_seeded_chk #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_chk (
  .clk      (clk),
  .clear_i  (clear_i),
  .seed_i   (seed_i),
  .state_o  (state_o),
  .serial_o (serial_o)
);

// File: tb/lfsr8_seeded_test.sv
module lfsr8_seeded_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clear_s = 1'b1;
  logic       seed_s  = 1'b0;
  logic [7:0] st;
  logic       ser;
  int checks = 0;
  int errors = 0;
  logic [7:0] model = 8'h00;

  lfsr8_seeded uut (
    .clk(clk), .clear_i(clear_s), .seed_i(seed_s),
    .state_o(st), .serial_o(ser)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit s, input string tag);
    int taps[3] = '{6, 5, 2};
    logic fb;
    @(negedge clk);
    clear_s = r;
    seed_s  = s;
    @(posedge clk);
    if (r) model = 8'h00;
    else if (s) model = 8'h80;
    else begin
      fb = model[0];
      foreach (taps[k]) fb = fb ^ model[taps[k]];
      model = {fb, model[7:1]};
    end
    #2;
    check(st === model, tag, st, model);
    check(ser === model[0], {tag, " R6 serial"}, ser, model[0]);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen[256];
    int distinct;
    step(1, 0, "R3 reset");
    step(1, 0, "R3 reset");
    // R7: all-zero state stays put
    for (int n = 0; n < 20; n++) begin
      step(0, 0, "R7 lockup");
      check(st === 8'h00, "R7 zero held", st, 0);
    end
    // R4 seed, then R1/R2/R8 full period
    step(0, 1, "R4 seed");
    for (int n = 0; n < 256; n++) seen[n] = 1'b0;
    distinct = 0;
    seen[st] = 1'b1;
    distinct = 1;
    for (int n = 1; n <= 255; n++) begin
      step(0, 0, "R1/R2 step");
      check(st !== 8'h00, "R8 no zero", st, 1);
      if (n < 255) begin
        check(st !== 8'h80, "R8 early return", st, 0);
        if (!seen[st]) begin
          seen[st] = 1'b1;
          distinct++;
        end
      end else begin
        check(st === 8'h80, "R8 period 255", st, 8'h80);
      end
    end
    check(distinct == 255, "R8 distinct states", distinct, 255);
    // some steps, then clear and seed together: R5
    for (int n = 0; n < 7; n++) step(0, 0, "R1/R2 step");
    step(1, 1, "R5 clear wins");
    check(st === 8'h00, "R5 result zero", st, 0);
    step(0, 0, "R7 lockup after R5");
    // reseed mid-run and hold seed
    step(0, 1, "R4 seed");
    step(0, 1, "R4 seed held");
    check(st === 8'h80, "R4 held value", st, 8'h80);
    for (int n = 0; n < 12; n++) step(0, 0, "R1/R2 step");
    step(1, 0, "R3 clear mid-run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule